// File: doc/BRIEF.md
# Coprocessor Context Save Sequencer

This block sits on the main-processor side and carries out a coprocessor context save once the destination address has already been resolved. A one-cycle `start` pulse, together with `base_addr`, begins the save. The sequencer first reads the coprocessor's save status register. No register write comes before that read. The sequencer then acts on the 16-bit format word that the read returns.

The upper byte of the format word selects the action:
- A not-ready code makes the sequencer hand control to interrupt servicing and then poll the status register again.
- An empty code stores the format word alone.
- Any other code stores the format word and then moves the coprocessor's state, one 32-bit word at a time, from the operand register to memory. The low byte of the format word gives the length in bytes.

A length that is not a whole number of words ends the save with a format-error pulse. The sequencer makes register reads and memory writes over two valid/ready channels and never has more than one access in flight.

Top module: `ctx_save_seq`

## Requirements
- R1: After `start`, the first bus access is a register read with `rd_sel`=0 (save status). No memory write takes place before a status read has returned a code other than not-ready.
- R2: A status word whose bits [15:8] equal 8'h01 (not-ready) causes no memory write. `irq_req` is raised and held until `irq_ack` is seen, and then the status register is read again. This repeats for as many not-ready replies as arrive.
- R3: For any other code, the first memory write goes to `base_addr`, with data {format[15:0], 16'h0000}. Here format is `rd_data[15:0]` from the status read.
- R4: When bits [15:8] equal 8'h00 (empty), only the format write takes place and the save then completes. The low byte is ignored for this code and is never checked for length.
- R5: For a non-empty code, `rd_data[7:0]` is the state length in bytes. This length does not count the format/null word. The sequencer makes exactly length/4 operand reads (`rd_sel`=1) and writes each returned word to memory.
- R6: When a non-empty code has a length that is not a multiple of four, `fmt_err` pulses for one cycle. In that case no memory write takes place, `done` stays low, and the sequencer returns to idle.
- R7: State word k (counting from 0) is written to `base_addr` + 4 + 4k, with the value of the k-th operand read.
- R8: `done` is high for exactly one cycle. It rises in the cycle after the handshake of the final memory write. `done` and `fmt_err` are never high together.
- R9: A non-empty code with length 0 produces the format write followed by `done`, with no operand read.
- R10: A request (`rd_valid`, `wr_valid` or `irq_req`) stays asserted with stable address, select and data until it is accepted. `rd_valid` and `wr_valid` are never high together.
- R11: A `start` pulse that arrives while a save is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a context save |
| base_addr | input | AW | Resolved destination address |
| rd_valid | output | 1 | Register read request |
| rd_sel | output | 1 | 0 = save status register, 1 = operand register |
| rd_ready | input | 1 | Read accepted, `rd_data` valid |
| rd_data | input | 32 | Register read data |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | AW | Memory write address |
| wr_data | output | 32 | Memory write data |
| wr_ready | input | 1 | Memory write accepted |
| irq_req | output | 1 | Request to service pending interrupts |
| irq_ack | input | 1 | Interrupt servicing finished |
| done | output | 1 | Save completed normally (one-cycle pulse) |
| fmt_err | output | 1 | Format error (one-cycle pulse) |

## Verification
Two things can coincide in one cycle: a memory write being accepted, which for the last word also finishes the save, and a fresh `start` pulse. The bench provokes this by raising `start` in exactly the cycle in which it grants each write handshake, including the final one.

The pass condition has three parts:
- The status register is read exactly once more than the number of not-ready replies.
- The write sequence is unchanged.
- `done` appears once, in the cycle after the last grant.

The bench runs this under pseudo-random ready stalls for every length from 0 to 40 bytes, two valid codes, the empty code and up to two not-ready retries.

// File: rtl/ctx_save_seq.sv
module ctx_save_seq #(
  parameter int          AW         = 32,
  parameter logic [7:0]  NR_CODE    = 8'h01,
  parameter logic [7:0]  EMPTY_CODE = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          rd_valid,
  output logic          rd_sel,
  input  logic          rd_ready,
  input  logic [31:0]   rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ready,
  output logic          irq_req,
  input  logic          irq_ack,
  output logic          done,
  output logic          fmt_err
);

  typedef enum logic [2:0] {IDLE, RD_STAT, WAIT_IRQ, WR_FMT, RD_OP, WR_OP} state_t;

  state_t        st;
  logic [AW-1:0] addr;
  logic [15:0]   fmt;
  logic [5:0]    left;
  logic [31:0]   opbuf;

  wire [7:0] code    = rd_data[15:8];
  wire       rd_take = rd_valid && rd_ready;
  wire       wr_take = wr_valid && wr_ready;

  assign rd_valid = (st == RD_STAT) || (st == RD_OP);
  assign rd_sel   = (st == RD_OP);
  assign wr_valid = (st == WR_FMT) || (st == WR_OP);
  assign wr_addr  = addr;
  assign wr_data  = (st == WR_FMT) ? {fmt, 16'h0000} : opbuf;
  assign irq_req  = (st == WAIT_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      addr    <= '0;
      fmt     <= '0;
      left    <= '0;
      opbuf   <= '0;
      done    <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      fmt_err <= 1'b0;
      case (st)
        IDLE:
          if (start) begin
            addr <= base_addr;
            st   <= RD_STAT;
          end
        RD_STAT:
          if (rd_take) begin
            if (code == NR_CODE) begin
              st <= WAIT_IRQ;
            end else if (code != EMPTY_CODE && rd_data[1:0] != 2'b00) begin
              fmt_err <= 1'b1;
              st      <= IDLE;
            end else begin
              fmt  <= rd_data[15:0];
              left <= (code == EMPTY_CODE) ? 6'd0 : rd_data[7:2];
              st   <= WR_FMT;
            end
          end
        WAIT_IRQ:
          if (irq_ack) st <= RD_STAT;
        WR_FMT:
          if (wr_take) begin
            addr <= addr + AW'(4);
            if (left == 6'd0) begin
              done <= 1'b1;
              st   <= IDLE;
            end else begin
              st <= RD_OP;
            end
          end
        RD_OP:
          if (rd_take) begin
            opbuf <= rd_data;
            st    <= WR_OP;
          end
        WR_OP:
          if (wr_take) begin
            addr <= addr + AW'(4);
            left <= left - 6'd1;
            if (left == 6'd1) begin
              done <= 1'b1;
              st   <= IDLE;
            end else begin
              st <= RD_OP;
            end
          end
        default: st <= IDLE;
      endcase
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_sel));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R2
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req);

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fmt_err));

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !rd_valid && !wr_valid && !irq_req);

endmodule

// File: tb/test_ctx_save_seq.sv
module test_ctx_save_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        rd_valid, rd_sel, wr_valid, irq_req, done, fmt_err;
  logic        rd_ready = 1'b0, wr_ready = 1'b0, irq_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic [31:0] wr_addr, wr_data;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  ctx_save_seq #(.AW(32)) i_ctx_save_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .irq_req(irq_req), .irq_ack(irq_ack), .done(done), .fmt_err(fmt_err)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] opval(input int id, input int k);
    return 32'hC0DE_0000 ^ (id << 8) ^ k;
  endfunction

  task automatic run_case(input logic [7:0] code, input logic [7:0] cnt, input int nr, input int id);
    int st_reads = 0, op_reads = 0, nwr = 0, irqs = 0, dones = 0, errs = 0;
    int cyc = 0, last_wr = -10, done_cyc = -1, tail = -1;
    logic exp_err = (code != 8'h00) && (cnt[1:0] != 2'b00);
    int   exp_words = (code == 8'h00) ? 0 : int'(cnt) / 4;
    logic [31:0] base = 32'h1000_0000 + id * 256;
    logic [31:0] ea, ed;
    @(negedge clk);
    base_addr = base;
    start = 1'b1;
    while (tail != 0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (tail > 0) tail--;
      if (done) begin dones++; if (done_cyc < 0) done_cyc = cyc; end
      if (fmt_err) errs++;
      if ((done || fmt_err) && tail < 0) tail = 3;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      start = 1'b0;
      rd_ready = rd_valid & lfsr[0];
      if (rd_ready) begin
        if (!rd_sel) begin
          rd_data = (st_reads < nr) ? 32'h0000_0100 : {16'h0, code, cnt};
          st_reads++;
        end else begin
          rd_data = opval(id, op_reads);
          op_reads++;
        end
      end
      wr_ready = wr_valid & lfsr[1];
      if (wr_ready) begin
        ea = base + 4 * nwr;
        ed = (nwr == 0) ? {code, cnt, 16'h0000} : opval(id, nwr - 1);
        // R1 R2: writes only after the final status read
        chk(st_reads == nr + 1, "R1", st_reads, nr + 1);
        // R3 R7: address and data of each write
        chk(wr_addr == ea, nwr == 0 ? "R3" : "R7", wr_addr, ea);
        chk(wr_data == ed, nwr == 0 ? "R3" : "R7", wr_data, ed);
        nwr++;
        last_wr = cyc;
        start = 1'b1; // R11: spurious start coincides with write grant
      end
      irq_ack = irq_req & lfsr[2];
      if (irq_ack) irqs++;
    end
    rd_ready = 1'b0; wr_ready = 1'b0; irq_ack = 1'b0; start = 1'b0;
    chk(cyc < 3000, "watchdog", cyc, 3000);
    chk(st_reads == nr + 1, "R2", st_reads, nr + 1);
    chk(irqs == nr, "R2", irqs, nr);
    chk(errs == int'(exp_err), "R6", errs, exp_err);
    chk(dones == int'(!exp_err), "R8", dones, !exp_err);
    chk(nwr == (exp_err ? 0 : 1 + exp_words), code == 8'h00 ? "R4" : "R5", nwr, exp_err ? 0 : 1 + exp_words);
    chk(op_reads == (exp_err ? 0 : exp_words), cnt == 0 ? "R9" : "R5", op_reads, exp_err ? 0 : exp_words);
    if (!exp_err) chk(done_cyc == last_wr + 1, "R8", done_cyc, last_wr + 1);
    chk(!rd_valid && !wr_valid && !irq_req, "R11", {rd_valid, wr_valid, irq_req}, 0);
  endtask

  initial begin
    int id = 0;
    repeat (3) @(negedge clk);
    // reset state
    chk(!rd_valid && !wr_valid && !irq_req && !done && !fmt_err, "R10",
        {rd_valid, wr_valid, irq_req, done, fmt_err}, 0);
    rst_n = 1'b1;
    for (int nr = 0; nr < 3; nr++) begin
      for (int c = 0; c <= 40; c++) begin
        run_case(8'h42, 8'(c), nr, id); id++;
        run_case(8'hFF, 8'(c), nr, id); id++;
      end
      run_case(8'h00, 8'd0, nr, id); id++;
      run_case(8'h00, 8'd3, nr, id); id++;
      run_case(8'h00, 8'd8, nr, id); id++;
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule